// File: doc/BRIEF.md
# BCH Bit-Flip Applicator

This block sits after a BCH error locator in a flash read path and turns the locator's bit indices into single-bit repairs on a stored 512-byte sector and its ECC field. The sector bytes and the stored ECC bytes live in one byte-wide memory outside the block. Data occupies addresses 0 to 511 and ECC byte k sits at address 512 + k. The block reaches that memory through a read-modify-write port with a read latency of one cycle.

An operation begins with a start pulse. The pulse carries the strength mode, the computed ECC bytes and the stored ECC bytes. The block first screens out two cases that need no locator work: a sector whose computed ECC is all zero (clean), and a sector whose stored ECC field reads as all ones (erased). Any other sector enters the correction phase. In that phase the block presents the computed ECC to the locator in reversed byte order and accepts locations one at a time through a valid/ready handshake. Each location is counted backward from the end of the codeword. It is mapped to a byte and a bit and then applied, or it is rejected as out of range. A final handshake from the locator closes the operation. The block then reports how many bits it flipped and whether anything went wrong.

Top module: `bchfix_core`

## Requirements
- R1: When start is accepted and the computed ECC bytes that belong to the codeword are all zero, done is high in the following cycle with clean=1, erased=0, fix_cnt=0, fail=0, and no memory access takes place. The bytes that belong to the codeword are bytes 0..12 in mode 0 and bytes 0..25 in mode 1. Byte k is calc_ecc[8k+7:8k]. In mode 0 the reserved byte 13 is ignored.
- R2: When the sector is not clean and every stored ECC byte of the field equals 8'hFF, done is high in the following cycle with erased=1, clean=0, fix_cnt=0, and no memory access takes place. The field is bytes 0..13 in mode 0 and 0..25 in mode 1. Otherwise the block stays busy and waits for locations.
- R3: From the cycle after start, rev_ecc holds the computed ECC in reversed order. In mode 1, rev byte i equals calc byte 25-i. In mode 0, rev byte i equals calc byte 12-i for i<13, rev byte 13 equals calc byte 13, and rev bytes 14..25 are zero.
- R4: Let E be 525 in mode 0 (strength 8) or 538 in mode 1 (strength 16), and let q = loc_bit/8. When q < E, the location flips bit (loc_bit mod 8) of memory address E-1-q. Addresses below 512 are sector data and addresses 512..E-1 are ECC byte (address-512).
- R5: A location with q >= E is accepted but causes no memory access, and it makes fail=1 when the operation ends.
- R6: Each repair is a read of the target address with mem_re=1, followed in the next cycle by a write to the same address with mem_we=1 and mem_wdata = mem_rdata XOR the bit mask. mem_re and mem_we are never high together. Two locations in the same byte both take effect.
- R7: At most 8 locations (mode 0) or 16 locations (mode 1) are processed per operation. A location beyond the limit is accepted, dropped with no memory access, and makes fail=1.
- R8: While waiting with loc_valid low, a lc_done pulse ends the operation. done is high in the next cycle with fix_cnt equal to the number of bytes written and fail = lc_fail OR any rejected or dropped location. busy falls in the same cycle.
- R9: A start pulse while busy is ignored. The operation, rev_ecc and the outputs continue unchanged.
- R10: loc_ready is high only while the block is busy and waiting for a location. It is low in idle and during a repair. After reset, busy, done, loc_ready, mem_re and mem_we are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 1 | 0 = strength 8 (14-byte field), 1 = strength 16 (26-byte field) |
| calc_ecc | input | 208 | Computed ECC bytes, byte k at bits 8k+7:8k |
| stored_ecc | input | 208 | ECC bytes read from the spare area, same layout |
| rev_ecc | output | 208 | Byte-reversed computed ECC for the locator |
| loc_valid | input | 1 | A location is offered |
| loc_bit | input | 13 | Bit index counted from the codeword end |
| loc_ready | output | 1 | Location accepted this cycle when loc_valid is high |
| lc_done | input | 1 | Locator has finished this sector |
| lc_fail | input | 1 | Locator could not resolve the sector |
| mem_addr | output | 10 | Byte address of the repair target |
| mem_re | output | 1 | Read strobe, data returns next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Repaired byte |
| mem_rdata | input | 8 | Byte read in the previous cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| clean | output | 1 | Last operation found a clean sector |
| erased | output | 1 | Last operation found an erased sector |
| fail | output | 1 | Last operation was not fully correctable |
| fix_cnt | output | 5 | Bits flipped in the last operation |

## Verification
Some rules hold on every cycle, and the assertions check these. The read and write strobes stay apart, and every write follows a read to the same address. The repair count never exceeds the strength limit. An accepted in-range location always lands inside the codeword. A completion pulse never overlaps busy. A clean result carries zero repairs. The reversed ECC stays stable during an operation. Other properties need the bench's scenarios and its byte-exact memory model to show them. These include the exact address and bit reached from a location at both area boundaries, the silent rejection of out-of-range and excess locations, the clean and erased screens, the reserved-byte exemption, the ignored start while busy, and two flips landing in one byte.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RD   = 2'd2,
      ST_WR   = 2'd3
   } fix_state_t;

   // index one past the last codeword byte; the reserved byte of the narrow field is outside
   function automatic int cw_end(input logic hi, input int data_b, input int lo_b, input int hi_b);
      return hi ? (data_b + hi_b) : (data_b + lo_b - 1);
   endfunction

endpackage

// File: rtl/bchfix_screen.sv
module bchfix_screen #(
   parameter int ECC_LO_BYTES = 14,
   parameter int ECC_HI_BYTES = 26
) (
   input  logic                      mode,
   input  logic [ECC_HI_BYTES*8-1:0] calc,
   input  logic [ECC_HI_BYTES*8-1:0] stored,
   output logic                      is_clean,
   output logic                      is_erased,
   output logic [ECC_HI_BYTES*8-1:0] rev
);
   logic [ECC_HI_BYTES-1:0] lo_zero, hi_zero, lo_ones, hi_ones;
   logic [ECC_HI_BYTES*8-1:0] rev_lo, rev_hi;

   if (ECC_LO_BYTES < 2 || ECC_LO_BYTES > ECC_HI_BYTES) begin : g_bad_field
      $error("bchfix_screen: narrow field must hold 2..ECC_HI_BYTES bytes");
   end

   for (genvar i = 0; i < ECC_HI_BYTES; i++) begin : g_byte
      assign hi_zero[i] = (calc[8*i +: 8] == 8'h00);
      assign hi_ones[i] = (stored[8*i +: 8] == 8'hFF);
      assign rev_hi[8*i +: 8] = calc[8*(ECC_HI_BYTES-1-i) +: 8];
      if (i < ECC_LO_BYTES - 1) begin : g_code
         assign lo_zero[i] = hi_zero[i];
         assign lo_ones[i] = hi_ones[i];
         assign rev_lo[8*i +: 8] = calc[8*(ECC_LO_BYTES-2-i) +: 8];
      end else if (i == ECC_LO_BYTES - 1) begin : g_resv
         assign lo_zero[i] = 1'b1;
         assign lo_ones[i] = hi_ones[i];
         assign rev_lo[8*i +: 8] = calc[8*i +: 8];
      end else begin : g_out
         assign lo_zero[i] = 1'b1;
         assign lo_ones[i] = 1'b1;
         assign rev_lo[8*i +: 8] = 8'h00;
      end
   end

   assign is_clean  = mode ? (&hi_zero) : (&lo_zero);
   assign is_erased = !is_clean && (mode ? (&hi_ones) : (&lo_ones));
   assign rev       = mode ? rev_hi : rev_lo;

endmodule

// File: rtl/bchfix_map.sv
module bchfix_map #(
   parameter int DATA_BYTES   = 512,
   parameter int ECC_LO_BYTES = 14,
   parameter int ECC_HI_BYTES = 26,
   parameter int LOC_W        = 13,
   parameter int ADDR_W       = 10
) (
   input  logic              mode,
   input  logic [LOC_W-1:0]  loc,
   output logic [ADDR_W-1:0] addr,
   output logic [7:0]        mask,
   output logic              bad
);
   import bchfix_pkg::*;

   localparam int LO_END = cw_end(1'b0, DATA_BYTES, ECC_LO_BYTES, ECC_HI_BYTES);
   localparam int HI_END = cw_end(1'b1, DATA_BYTES, ECC_LO_BYTES, ECC_HI_BYTES);

   if (LOC_W < 4 || LOC_W > 30) begin : g_bad_loc
      $error("bchfix_map: LOC_W out of range");
   end
   if ((1 << ADDR_W) < HI_END) begin : g_bad_addr
      $error("bchfix_map: ADDR_W too small for the codeword");
   end

   logic [31:0] byte_from_end, end_pos;

   assign byte_from_end = 32'(loc >> 3);
   assign end_pos       = mode ? 32'(HI_END) : 32'(LO_END);
   assign bad           = (byte_from_end >= end_pos);
   assign addr          = ADDR_W'(end_pos - byte_from_end - 32'd1);
   assign mask          = 8'd1 << loc[2:0];

endmodule

// File: rtl/bchfix_core.sv
module bchfix_core #(
   parameter int DATA_BYTES   = 512,
   parameter int ECC_LO_BYTES = 14,
   parameter int ECC_HI_BYTES = 26,
   parameter int LO_T         = 8,
   parameter int HI_T         = 16,
   parameter int LOC_W        = 13,
   parameter int ADDR_W       = $clog2(DATA_BYTES + ECC_HI_BYTES),
   parameter int CNT_W        = $clog2(HI_T + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      mode,
   input  logic [ECC_HI_BYTES*8-1:0] calc_ecc,
   input  logic [ECC_HI_BYTES*8-1:0] stored_ecc,
   output logic [ECC_HI_BYTES*8-1:0] rev_ecc,
   input  logic                      loc_valid,
   input  logic [LOC_W-1:0]          loc_bit,
   output logic                      loc_ready,
   input  logic                      lc_done,
   input  logic                      lc_fail,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic                      mem_re,
   output logic                      mem_we,
   output logic [7:0]                mem_wdata,
   input  logic [7:0]                mem_rdata,
   output logic                      busy,
   output logic                      done,
   output logic                      clean,
   output logic                      erased,
   output logic                      fail,
   output logic [CNT_W-1:0]          fix_cnt
);
   import bchfix_pkg::*;

   localparam int LO_END = cw_end(1'b0, DATA_BYTES, ECC_LO_BYTES, ECC_HI_BYTES);
   localparam int HI_END = cw_end(1'b1, DATA_BYTES, ECC_LO_BYTES, ECC_HI_BYTES);

   if (LO_T < 1 || LO_T > HI_T) begin : g_bad_limit
      $error("bchfix_core: strength limits must satisfy 1 <= LO_T <= HI_T");
   end

   fix_state_t                st;
   logic                      mode_r, err_r;
   logic [CNT_W-1:0]          taken, limit;
   logic [ADDR_W-1:0]         tgt_addr, map_addr;
   logic [7:0]                tgt_mask, map_mask;
   logic                      map_bad, scr_clean, scr_erased;
   logic [ECC_HI_BYTES*8-1:0] scr_rev;

   bchfix_screen #(
      .ECC_LO_BYTES(ECC_LO_BYTES),
      .ECC_HI_BYTES(ECC_HI_BYTES)
   ) u_screen (
      .mode     (mode),
      .calc     (calc_ecc),
      .stored   (stored_ecc),
      .is_clean (scr_clean),
      .is_erased(scr_erased),
      .rev      (scr_rev)
   );

   bchfix_map #(
      .DATA_BYTES  (DATA_BYTES),
      .ECC_LO_BYTES(ECC_LO_BYTES),
      .ECC_HI_BYTES(ECC_HI_BYTES),
      .LOC_W       (LOC_W),
      .ADDR_W      (ADDR_W)
   ) u_map (
      .mode(mode_r),
      .loc (loc_bit),
      .addr(map_addr),
      .mask(map_mask),
      .bad (map_bad)
   );

   assign limit     = mode_r ? CNT_W'(HI_T) : CNT_W'(LO_T);
   assign loc_ready = (st == ST_WAIT);
   assign busy      = (st != ST_IDLE);
   assign mem_re    = (st == ST_RD);
   assign mem_we    = (st == ST_WR);
   assign mem_addr  = tgt_addr;
   assign mem_wdata = mem_rdata ^ tgt_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         mode_r   <= 1'b0;
         err_r    <= 1'b0;
         taken    <= '0;
         tgt_addr <= '0;
         tgt_mask <= '0;
         rev_ecc  <= '0;
         done     <= 1'b0;
         clean    <= 1'b0;
         erased   <= 1'b0;
         fail     <= 1'b0;
         fix_cnt  <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               mode_r  <= mode;
               rev_ecc <= scr_rev;
               clean   <= scr_clean;
               erased  <= scr_erased;
               fail    <= 1'b0;
               err_r   <= 1'b0;
               fix_cnt <= '0;
               taken   <= '0;
               if (scr_clean || scr_erased) done <= 1'b1;
               else                         st   <= ST_WAIT;
            end
            ST_WAIT: begin
               if (loc_valid) begin
                  if (taken < limit) taken <= taken + 1'b1;
                  if (taken >= limit || map_bad) begin
                     err_r <= 1'b1;
                  end else begin
                     tgt_addr <= map_addr;
                     tgt_mask <= map_mask;
                     st       <= ST_RD;
                  end
               end else if (lc_done) begin
                  done <= 1'b1;
                  fail <= err_r | lc_fail;
                  st   <= ST_IDLE;
               end
            end
            ST_RD: st <= ST_WR;
            ST_WR: begin
               fix_cnt <= fix_cnt + 1'b1;
               st      <= ST_WAIT;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r6_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   a_r6_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(mem_re) && $stable(mem_addr)));

   a_r7_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
      fix_cnt <= limit);

   a_r4_lands_in_codeword: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_valid && loc_ready && !map_bad) |->
         (int'(map_addr) < (mode_r ? HI_END : LO_END)));

   a_r1_clean_has_no_fix: assert property (@(posedge clk) disable iff (!rst_n)
      (done && clean) |-> (fix_cnt == '0 && !fail && !erased));

   a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r9_rev_stable_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(rev_ecc));

   a_r10_ready_not_in_repair: assert property (@(posedge clk) disable iff (!rst_n)
      loc_ready |-> (busy && !mem_re && !mem_we));

endmodule

// File: tb/tb_bchfix_core.sv
module tb_bchfix_core;
   localparam int NB = 538;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0, mode = 1'b0;
   logic [207:0] calc_ecc = '0, stored_ecc = '0;
   logic [207:0] rev_ecc;
   logic         loc_valid = 1'b0;
   logic [12:0]  loc_bit = '0;
   logic         loc_ready, lc_done = 1'b0, lc_fail = 1'b0;
   logic [9:0]   mem_addr;
   logic         mem_re, mem_we;
   logic [7:0]   mem_wdata, mem_rdata;
   logic         busy, done, clean, erased, fail;
   logic [4:0]   fix_cnt;

   logic [7:0]   mem [0:NB-1];
   int           exp_mem [0:NB-1];
   int           wq_addr[$];
   int           wq_data[$];
   int           n_chk = 0, n_bad = 0;
   int           m_mode, m_taken, m_fix;
   bit           m_err;

   always #10 clk = ~clk;

   bchfix_core dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .calc_ecc(calc_ecc), .stored_ecc(stored_ecc), .rev_ecc(rev_ecc),
      .loc_valid(loc_valid), .loc_bit(loc_bit), .loc_ready(loc_ready),
      .lc_done(lc_done), .lc_fail(lc_fail),
      .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .clean(clean), .erased(erased),
      .fail(fail), .fix_cnt(fix_cnt)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NB; i++) mem[i] <= 8'((i * 7 + 3) & 255);
         mem_rdata <= 8'h00;
      end else begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         if (mem_re) mem_rdata <= mem[mem_addr];
      end
   end

   task automatic chk(input string tag, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // cycle-by-cycle comparison of every write against the model's queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_re && mem_we) chk("R6 strobes overlap", 1, 0);
         if (mem_we) begin
            if (wq_addr.size() == 0) begin
               chk("R5/R7 unexpected write addr", int'(mem_addr), -1);
            end else begin
               chk("R4 write address", int'(mem_addr), wq_addr.pop_front());
               chk("R6 write data", int'(mem_wdata), wq_data.pop_front());
            end
         end
      end
   end

   task automatic report();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(20ns * 150000);
      chk("watchdog expired", 1, 0);
      report();
   end

   task automatic begin_op(input int md, input logic [207:0] c, input logic [207:0] s);
      mode = md[0]; calc_ecc = c; stored_ecc = s; start = 1'b1;
      m_mode = md; m_taken = 0; m_fix = 0; m_err = 0;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic send_loc(input int l);
      int e, q, lim, pos, msk;
      e = (m_mode != 0) ? 538 : 525;
      lim = (m_mode != 0) ? 16 : 8;
      q = l / 8;
      if (m_taken >= lim || q >= e) m_err = 1;
      else begin
         pos = e - 1 - q;
         msk = 1 << (l % 8);
         wq_addr.push_back(pos);
         wq_data.push_back(exp_mem[pos] ^ msk);
         exp_mem[pos] = exp_mem[pos] ^ msk;
         m_fix++;
      end
      m_taken++;
      loc_bit = 13'(l); loc_valid = 1'b1;
      while (!loc_ready) @(negedge clk);
      @(negedge clk);
      loc_valid = 1'b0;
   endtask

   task automatic end_op(input bit lf, input string tag);
      while (!loc_ready) @(negedge clk);
      lc_done = 1'b1; lc_fail = lf;
      @(negedge clk);
      lc_done = 1'b0; lc_fail = 1'b0;
      chk({tag, " done"}, int'(done), 1);
      chk({tag, " busy"}, int'(busy), 0);
      chk({tag, " fix_cnt"}, int'(fix_cnt), m_fix);
      chk({tag, " fail"}, int'(fail), int'(m_err | lf));
   endtask

   task automatic cmp_mem(input string tag);
      int mis = 0;
      for (int i = 0; i < NB; i++) if (int'(mem[i]) != exp_mem[i]) mis++;
      chk({tag, " memory image mismatches"}, mis, 0);
      chk({tag, " pending writes"}, wq_addr.size(), 0);
   endtask

   initial begin
      logic [207:0] c, s, er;
      int mis;
      for (int i = 0; i < NB; i++) exp_mem[i] = (i * 7 + 3) & 255;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk("R10 reset busy", int'(busy), 0);
      chk("R10 reset done", int'(done), 0);
      chk("R10 reset loc_ready", int'(loc_ready), 0);
      chk("R10 reset mem_we", int'(mem_we | mem_re), 0);

      // R1 clean, reserved byte 13 and out-of-field bytes nonzero
      c = '0; c[8*13 +: 8] = 8'h5A; c[8*20 +: 8] = 8'h11;
      begin_op(0, c, '0);
      chk("R1 done", int'(done), 1);
      chk("R1 clean", int'(clean), 1);
      chk("R1 erased", int'(erased), 0);
      chk("R1 fix_cnt", int'(fix_cnt), 0);
      chk("R1 busy", int'(busy), 0);

      // R2 erased, wide field
      c = '0; c[7:0] = 8'h01;
      begin_op(1, c, {26{8'hFF}});
      chk("R2 wide done", int'(done), 1);
      chk("R2 wide erased", int'(erased), 1);
      chk("R2 wide clean", int'(clean), 0);

      // R2 erased, narrow field ignores bytes above 13
      c = '0; c[8*5 +: 8] = 8'h03;
      s = '0; s[14*8-1:0] = {14{8'hFF}};
      begin_op(0, c, s);
      chk("R2 narrow erased", int'(erased), 1);
      chk("R2 narrow done", int'(done), 1);

      // narrow correction: R2 not erased, R3 reversal, R4 boundaries, R5 invalid
      for (int i = 0; i < 26; i++) c[8*i +: 8] = 8'(i + 1);
      s = {26{8'hFF}}; s[8*13 +: 8] = 8'hFE;
      begin_op(0, c, s);
      chk("R2 not erased busy", int'(busy), 1);
      chk("R2 not erased done", int'(done), 0);
      mis = 0;
      for (int i = 0; i < 26; i++) begin
         int ev;
         ev = (i < 13) ? (13 - i) : ((i == 13) ? 14 : 0);
         if (int'(rev_ecc[8*i +: 8]) != ev) mis++;
      end
      chk("R3 narrow reversal mismatches", mis, 0);
      send_loc(0);
      send_loc(103);
      send_loc(104);
      send_loc(4197);
      send_loc(4200);
      end_op(1'b0, "R5 narrow");
      cmp_mem("R4 narrow");

      // wide correction: R3, R4 boundaries, R6 same byte twice, R9 start ignored
      for (int i = 0; i < 26; i++) c[8*i +: 8] = 8'(40 + i);
      begin_op(1, c, '0);
      er = '0;
      for (int i = 0; i < 26; i++) er[8*i +: 8] = 8'(40 + 25 - i);
      chk("R3 wide reversal", int'(rev_ecc == er), 1);
      send_loc(207);
      send_loc(208);
      start = 1'b1; calc_ecc = '0; mode = 1'b0;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R9 start ignored done", int'(done), 0);
      chk("R9 start ignored busy", int'(busy), 1);
      chk("R9 start ignored rev", int'(rev_ecc == er), 1);
      send_loc(4303);
      send_loc(1000);
      send_loc(1001);
      send_loc(4304);
      end_op(1'b0, "R6 wide");
      cmp_mem("R6 wide");

      // R7 wide limit of 16
      c = '0; c[8*25 +: 8] = 8'h80;
      begin_op(1, c, '0);
      for (int k = 0; k < 17; k++) send_loc(300 + k * 9);
      end_op(1'b0, "R7 wide limit");
      cmp_mem("R7 wide limit");

      // R7 narrow limit of 8
      c = '0; c[7:0] = 8'h44;
      begin_op(0, c, '0);
      for (int k = 0; k < 9; k++) send_loc(2000 + k);
      end_op(1'b0, "R7 narrow limit");
      cmp_mem("R7 narrow limit");

      // R8 locator failure with no locations
      begin_op(0, c, '0);
      chk("R10 ready while waiting", int'(loc_ready), 1);
      end_op(1'b1, "R8 locator fail");

      // R6 same location twice restores the byte
      begin_op(1, c, '0);
      send_loc(777);
      send_loc(777);
      end_op(1'b0, "R6 twice");
      cmp_mem("R6 twice");

      repeat (3) @(negedge clk);
      report();
   end
endmodule